// File: doc/BRIEF.md
# SGMII Configuration Word Exchanger

This block runs the link-configuration handshake of an SGMII-style serial link at the level of 16-bit configuration words. A static role input decides which end of the asymmetric exchange the block plays. As the PHY-side end it keeps sending a word that reports link state, duplex and speed taken from its local input pins. It then waits for the partner to echo an acknowledge. As the MAC-side end it listens for the partner's report, latches the link, duplex and speed it carries, and answers with the fixed acknowledge word. Two blocks wired back to back therefore only complete when one is strapped to each role.

Words enter and leave on parallel ports qualified by a valid strobe. Serialization, line coding, ordered-set framing and the register bus sit outside the block. Software sees the result through a sticky completion flag, which it clears with a write-zero strobe. While the exchange is still in flight it can also read the partner status, which disappears once the exchange completes. After completion it reads a resolved view: speed on two control bits and duplex on two advertisement bits. A restart input throws all of this away and starts over.

The controller has five states. The block starts in IDLE. IDLE moves to LISTEN (MAC role) or ADVERT (PHY role) after one cycle. LISTEN moves to ACK when a partner word is accepted. ACK moves to DONE after a fixed number of acknowledge cycles. ADVERT moves directly to DONE when an acknowledge is accepted. DONE holds until restart, which returns any state to IDLE.

Top module: `sgmii_cfg_xchg`

## Requirements
- R1: After reset or restart the block spends exactly one cycle in IDLE, then enters LISTEN when role_phy is 0 or ADVERT when role_phy is 1. tx_valid is 0 in IDLE and LISTEN.
- R2: In the PHY role, from ADVERT on, tx_valid is 1 and tx_word carries loc_link in bit 15, loc_full_duplex in bit 12 (1 = full) and loc_speed in bits 11:10, with bit 0 at 1 and all other bits at 0.
- R3: In the MAC role, in ACK and DONE, tx_valid is 1 and tx_word is 16'h4001: bit 14 is the acknowledge, bit 0 is set, and all other bits are 0.
- R4: A received word is accepted only on the third consecutive identical qualifying copy, and it must have bit 0 set. Cycles with rx_valid low do not break a run. A differing word starts a new run.
- R5: In the MAC role, a word whose speed field (bits 11:10) is the reserved code 2'b11 never qualifies. It is not accepted, and the speed latched earlier is kept.
- R6: In the MAC role, acceptance in LISTEN latches bit 15 (link), bit 12 (duplex) and bits 11:10 (speed, 10 = 1000 Mb/s, 01 = 100 Mb/s, 00 = 10 Mb/s). The latched values appear on rx_stat_* for the ACK_CYCLES cycles of ACK. On entry to DONE, rx_stat_* reads zero and an_done rises.
- R7: In the PHY role, completion needs three consecutive identical copies that have bit 14 set (and bit 0 set). On completion an_done rises and the local link, duplex and speed are latched as the resolved status.
- R8: an_done stays 1 until an irq_clr pulse or a restart clears it. If a new completion and irq_clr fall in the same cycle, the completion wins.
- R9: In DONE, res_ctrl has only bit 6 set for 1000 Mb/s and only bit 13 set for 100 Mb/s, and is 0 for 10 Mb/s. Outside DONE it is 0.
- R10: In DONE, res_adv has bit 5 set for full duplex or bit 6 set for half duplex, and res_link shows the resolved link. Outside DONE both are 0.
- R11: Restart clears an_done, the latched status, the copy counter and the resolved outputs by the next cycle.
- R12: In the MAC role, a newly accepted word while in DONE updates the resolved status without leaving DONE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Synchronous return to IDLE with status cleared |
| role_phy | input | 1 | Static role: 1 = PHY side, 0 = MAC side |
| loc_link | input | 1 | Local link state sent in the PHY role |
| loc_full_duplex | input | 1 | Local duplex sent in the PHY role (1 = full) |
| loc_speed | input | 2 | Local speed code sent in the PHY role |
| rx_valid | input | 1 | Received word strobe |
| rx_word | input | 16 | Received configuration word |
| irq_clr | input | 1 | Write-zero strobe that clears an_done |
| tx_valid | output | 1 | Transmit word is valid |
| tx_word | output | 16 | Transmitted configuration word |
| an_done | output | 1 | Sticky completion flag |
| rx_stat_link | output | 1 | Partner link while the exchange is in flight |
| rx_stat_full_duplex | output | 1 | Partner duplex while the exchange is in flight |
| rx_stat_speed | output | 2 | Partner speed while the exchange is in flight |
| res_link | output | 1 | Resolved link after completion |
| res_ctrl | output | 16 | Resolved speed on bits 13 and 6 |
| res_adv | output | 16 | Resolved duplex on bits 5 and 6 |

## Verification
The assertions check on every cycle the properties that hold regardless of history:
- the fixed bits of every transmitted word and the exact acknowledge word in the MAC role;
- the mutual exclusion of the resolved speed bits and of the resolved duplex bits;
- that an_done stays set unless cleared;
- that partner status is gone at the moment of completion;
- that everything is cleared after restart.

Only the bench scenarios can show the rest. These include:
- the three-copy run rule with interruptions and gaps;
- that a reserved speed code is ignored;
- the relatch of status while in DONE;
- the exact mapping of every link, duplex and speed combination onto the transmitted and resolved fields, swept over all sixteen combinations in both roles.

// File: rtl/sgx_pkg.sv
package sgx_pkg;

    localparam int CW_W       = 16;
    localparam int BIT_LINK   = 15;
    localparam int BIT_ACK    = 14;
    localparam int BIT_DUPLEX = 12;
    localparam int SPD_LSB    = 10;
    localparam int BIT_SYNC   = 0;

    localparam int RES_1G_BIT   = 6;
    localparam int RES_100M_BIT = 13;
    localparam int ADV_FULL_BIT = 5;
    localparam int ADV_HALF_BIT = 6;

    localparam logic [CW_W-1:0] MAC_ACK_WORD = 16'h4001;

    typedef enum logic [1:0] {
        SPD_10M  = 2'b00,
        SPD_100M = 2'b01,
        SPD_1G   = 2'b10,
        SPD_RSVD = 2'b11
    } sgx_speed_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LISTEN,
        ST_ADVERT,
        ST_ACK,
        ST_DONE
    } sgx_state_e;

    function automatic logic [CW_W-1:0] phy_word(input logic link,
                                                 input logic full_dup,
                                                 input logic [1:0] spd);
        logic [CW_W-1:0] w;
        w               = '0;
        w[BIT_LINK]     = link;
        w[BIT_DUPLEX]   = full_dup;
        w[SPD_LSB +: 2] = spd;
        w[BIT_SYNC]     = 1'b1;
        return w;
    endfunction

endpackage

// File: rtl/sgx_copy_filter.sv
module sgx_copy_filter #(
    parameter int WORD_W = 16,
    parameter int COPIES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    input  logic              qualify,
    output logic              accept
);
    localparam int CNT_W = $clog2(COPIES + 1);
    localparam logic [CNT_W-1:0] LAST_BEFORE = CNT_W'(COPIES - 1);
    localparam logic [CNT_W-1:0] FULL_RUN    = CNT_W'(COPIES);

    logic [WORD_W-1:0] last_q;
    logic [CNT_W-1:0]  run_q;
    logic              same;

    assign same   = (run_q != '0) && (in_word == last_q);
    assign accept = in_valid && qualify && same && (run_q == LAST_BEFORE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= '0;
            run_q  <= '0;
        end else if (clr) begin
            last_q <= '0;
            run_q  <= '0;
        end else if (in_valid) begin
            last_q <= in_word;
            if (!qualify) begin
                run_q <= '0;
            end else if (same) begin
                if (run_q != FULL_RUN) run_q <= run_q + 1'b1;
            end else begin
                run_q <= CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/sgx_word_builder.sv
module sgx_word_builder
    import sgx_pkg::*;
(
    input  logic            role_phy,
    input  logic            active,
    input  logic            link,
    input  logic            full_dup,
    input  logic [1:0]      spd,
    output logic            word_valid,
    output logic [CW_W-1:0] word
);
    always_comb begin
        word_valid = active;
        if (!active)       word = '0;
        else if (role_phy) word = phy_word(link, full_dup, spd);
        else               word = MAC_ACK_WORD;
    end
endmodule

// File: rtl/sgx_status_map.sv
module sgx_status_map
    import sgx_pkg::*;
(
    input  logic            in_done,
    input  logic            link,
    input  logic            full_dup,
    input  logic [1:0]      spd,
    output logic            res_link,
    output logic [CW_W-1:0] res_ctrl,
    output logic [CW_W-1:0] res_adv
);
    always_comb begin
        res_link = 1'b0;
        res_ctrl = '0;
        res_adv  = '0;
        if (in_done) begin
            res_link = link;
            unique case (sgx_speed_e'(spd))
                SPD_1G:   res_ctrl[RES_1G_BIT]   = 1'b1;
                SPD_100M: res_ctrl[RES_100M_BIT] = 1'b1;
                SPD_10M:  res_ctrl               = '0;
                SPD_RSVD: res_ctrl               = '0;
                default:  res_ctrl               = '0;
            endcase
            if (full_dup) res_adv[ADV_FULL_BIT] = 1'b1;
            else          res_adv[ADV_HALF_BIT] = 1'b1;
        end
    end
endmodule

// File: rtl/sgmii_cfg_xchg.sv
module sgmii_cfg_xchg
    import sgx_pkg::*;
#(
    parameter int COPIES     = 3,
    parameter int ACK_CYCLES = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart,
    input  logic            role_phy,
    input  logic            loc_link,
    input  logic            loc_full_duplex,
    input  logic [1:0]      loc_speed,
    input  logic            rx_valid,
    input  logic [CW_W-1:0] rx_word,
    input  logic            irq_clr,
    output logic            tx_valid,
    output logic [CW_W-1:0] tx_word,
    output logic            an_done,
    output logic            rx_stat_link,
    output logic            rx_stat_full_duplex,
    output logic [1:0]      rx_stat_speed,
    output logic            res_link,
    output logic [CW_W-1:0] res_ctrl,
    output logic [CW_W-1:0] res_adv
);
    localparam int ACK_W = $clog2(ACK_CYCLES + 1);
    localparam logic [ACK_W-1:0] ACK_LAST = ACK_W'(ACK_CYCLES - 1);

    sgx_state_e       state_q, state_d;
    logic [ACK_W-1:0] ack_q;
    logic             lat_link_q, lat_dup_q;
    logic [1:0]       lat_spd_q;
    logic             done_q;
    logic             qualify, accept;
    logic             tx_active, in_done, in_ack;
    logic             mac_load, phy_load;

    // qualification of a received copy depends on the role
    always_comb begin
        if (role_phy) qualify = rx_word[BIT_SYNC] && rx_word[BIT_ACK];
        else          qualify = rx_word[BIT_SYNC] &&
                                (rx_word[SPD_LSB +: 2] != SPD_RSVD);
    end

    sgx_copy_filter #(.WORD_W(CW_W), .COPIES(COPIES)) u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (restart),
        .in_valid (rx_valid),
        .in_word  (rx_word),
        .qualify  (qualify),
        .accept   (accept)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = role_phy ? ST_ADVERT : ST_LISTEN;
            ST_LISTEN: if (accept) state_d = ST_ACK;
            ST_ADVERT: if (accept) state_d = ST_DONE;
            ST_ACK:    if (ack_q == ACK_LAST) state_d = ST_DONE;
            ST_DONE:   state_d = ST_DONE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       state_q <= ST_IDLE;
        else if (restart) state_q <= ST_IDLE;
        else              state_q <= state_d;
    end

    // acknowledge cycle counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          ack_q <= '0;
        else if (restart || state_q != ST_ACK) ack_q <= '0;
        else                                 ack_q <= ack_q + 1'b1;
    end

    assign mac_load = !role_phy && accept &&
                      (state_q == ST_LISTEN || state_q == ST_DONE);
    assign phy_load = role_phy && accept && (state_q == ST_ADVERT);

    // latched partner or local status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_link_q <= 1'b0;
            lat_dup_q  <= 1'b0;
            lat_spd_q  <= SPD_10M;
        end else if (restart) begin
            lat_link_q <= 1'b0;
            lat_dup_q  <= 1'b0;
            lat_spd_q  <= SPD_10M;
        end else if (mac_load) begin
            lat_link_q <= rx_word[BIT_LINK];
            lat_dup_q  <= rx_word[BIT_DUPLEX];
            lat_spd_q  <= rx_word[SPD_LSB +: 2];
        end else if (phy_load) begin
            lat_link_q <= loc_link;
            lat_dup_q  <= loc_full_duplex;
            lat_spd_q  <= loc_speed;
        end
    end

    // sticky completion flag, set wins over clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                        done_q <= 1'b0;
        else if (restart)                                  done_q <= 1'b0;
        else if (state_d == ST_DONE && state_q != ST_DONE) done_q <= 1'b1;
        else if (irq_clr)                                  done_q <= 1'b0;
    end

    // output decode
    always_comb begin
        tx_active = 1'b0;
        in_done   = 1'b0;
        in_ack    = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_LISTEN: ;
            ST_ADVERT: tx_active = 1'b1;
            ST_ACK:    begin tx_active = 1'b1; in_ack = 1'b1; end
            ST_DONE:   begin tx_active = 1'b1; in_done = 1'b1; end
            default:   ;
        endcase
        an_done             = done_q;
        rx_stat_link        = in_ack & lat_link_q;
        rx_stat_full_duplex = in_ack & lat_dup_q;
        rx_stat_speed       = in_ack ? lat_spd_q : 2'b00;
    end

    sgx_word_builder u_tx (
        .role_phy   (role_phy),
        .active     (tx_active),
        .link       (loc_link),
        .full_dup   (loc_full_duplex),
        .spd        (loc_speed),
        .word_valid (tx_valid),
        .word       (tx_word)
    );

    sgx_status_map u_res (
        .in_done  (in_done),
        .link     (lat_link_q),
        .full_dup (lat_dup_q),
        .spd      (lat_spd_q),
        .res_link (res_link),
        .res_ctrl (res_ctrl),
        .res_adv  (res_adv)
    );
endmodule

// File: rtl/sgx_checker.sv
module sgx_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        restart,
    input logic        role_phy,
    input logic        rx_valid,
    input logic [15:0] rx_word,
    input logic        irq_clr,
    input logic        tx_valid,
    input logic [15:0] tx_word,
    input logic        an_done,
    input logic        rx_stat_link,
    input logic        rx_stat_full_duplex,
    input logic [1:0]  rx_stat_speed,
    input logic        res_link,
    input logic [15:0] res_ctrl,
    input logic [15:0] res_adv
);
    AST_TX_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (tx_word[0] && !tx_word[13] && tx_word[9:1] == 9'd0)); // R2
    AST_MAC_ACK_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !role_phy) |-> (tx_word == 16'h4001)); // R3
    AST_MAC_ACK_AFTER_RX: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tx_valid) && !role_phy && !$past(restart)) |-> $past(rx_valid)); // R4
    AST_STAT_GONE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(an_done) |-> (!rx_stat_link && !rx_stat_full_duplex && rx_stat_speed == 2'b00)); // R6
    AST_PHY_DONE_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(an_done) && role_phy) |-> ($past(rx_valid) && $past(rx_word[14]))); // R7
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (an_done && !irq_clr && !restart) |=> an_done); // R8
    AST_CTRL_ONE_SPEED: assert property (@(posedge clk) disable iff (!rst_n)
        ($onehot0({res_ctrl[13], res_ctrl[6]}) && (res_ctrl & 16'hDFBF) == 16'h0000)); // R9
    AST_ADV_ONE_DUPLEX: assert property (@(posedge clk) disable iff (!rst_n)
        ($onehot0(res_adv) && (res_adv & 16'hFF9F) == 16'h0000)); // R10
    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!an_done && !tx_valid && !res_link && res_ctrl == 16'h0 && res_adv == 16'h0)); // R11
endmodule

bind sgmii_cfg_xchg sgx_checker u_sgx_checker (
    .clk                 (clk),
    .rst_n               (rst_n),
    .restart             (restart),
    .role_phy            (role_phy),
    .rx_valid            (rx_valid),
    .rx_word             (rx_word),
    .irq_clr             (irq_clr),
    .tx_valid            (tx_valid),
    .tx_word             (tx_word),
    .an_done             (an_done),
    .rx_stat_link        (rx_stat_link),
    .rx_stat_full_duplex (rx_stat_full_duplex),
    .rx_stat_speed       (rx_stat_speed),
    .res_link            (res_link),
    .res_ctrl            (res_ctrl),
    .res_adv             (res_adv)
);

// File: tb/tb_sgmii_cfg_xchg.sv
module tb_sgmii_cfg_xchg;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        restart = 1'b0;
    logic        role_phy = 1'b0;
    logic        loc_link = 1'b0;
    logic        loc_full_duplex = 1'b0;
    logic [1:0]  loc_speed = 2'b00;
    logic        rx_valid = 1'b0;
    logic [15:0] rx_word = 16'h0;
    logic        irq_clr = 1'b0;
    logic        tx_valid;
    logic [15:0] tx_word;
    logic        an_done;
    logic        rx_stat_link;
    logic        rx_stat_full_duplex;
    logic [1:0]  rx_stat_speed;
    logic        res_link;
    logic [15:0] res_ctrl;
    logic [15:0] res_adv;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sgmii_cfg_xchg dut (
        .clk(clk), .rst_n(rst_n), .restart(restart), .role_phy(role_phy),
        .loc_link(loc_link), .loc_full_duplex(loc_full_duplex), .loc_speed(loc_speed),
        .rx_valid(rx_valid), .rx_word(rx_word), .irq_clr(irq_clr),
        .tx_valid(tx_valid), .tx_word(tx_word), .an_done(an_done),
        .rx_stat_link(rx_stat_link), .rx_stat_full_duplex(rx_stat_full_duplex),
        .rx_stat_speed(rx_stat_speed), .res_link(res_link),
        .res_ctrl(res_ctrl), .res_adv(res_adv)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input int l, input int d, input int s);
        return 16'((l << 15) | (d << 12) | (s << 10) | 1);
    endfunction

    function automatic logic [15:0] exp_ctrl(input int s);
        return (s == 2) ? 16'h0040 : (s == 1) ? 16'h2000 : 16'h0000;
    endfunction

    function automatic logic [15:0] exp_adv(input int d);
        return (d != 0) ? 16'h0020 : 16'h0040;
    endfunction

    task automatic push(input logic [15:0] w);
        @(negedge clk); rx_valid = 1'b1; rx_word = w;
        @(negedge clk); rx_valid = 1'b0; rx_word = 16'h0;
    endtask

    task automatic push3(input logic [15:0] w);
        push(w); push(w); push(w);
    endtask

    task automatic do_restart();
        @(negedge clk); restart = 1'b1;
        @(negedge clk); restart = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 reset an_done", {15'h0, an_done}, 16'h0);
        chk("R1 reset tx_valid", {15'h0, tx_valid}, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        // IDLE -> LISTEN: MAC role stays silent
        chk("R1 listen no tx", {15'h0, tx_valid}, 16'h0);

        // MAC role sweep over all link/duplex/speed combinations
        role_phy = 1'b0;
        for (int c = 0; c < 16; c++) begin
            int l = (c >> 3) & 1;
            int d = (c >> 2) & 1;
            int s = c & 3;
            do_restart();
            push3(mk(l, d, s));
            if (s == 3) begin
                repeat (3) @(negedge clk);
                chk("R5 reserved not accepted tx_valid", {15'h0, tx_valid}, 16'h0);
                chk("R5 reserved not accepted done", {15'h0, an_done}, 16'h0);
            end else begin
                chk("R3 ack word", tx_word, 16'h4001);
                chk("R6 stat during ack", {12'h0, rx_stat_link, rx_stat_full_duplex, rx_stat_speed},
                    16'((l << 3) | (d << 2) | s));
                chk("R6 not done yet", {15'h0, an_done}, 16'h0);
                repeat (3) @(negedge clk);
                chk("R6 done set", {15'h0, an_done}, 16'h1);
                chk("R6 stat cleared", {12'h0, rx_stat_link, rx_stat_full_duplex, rx_stat_speed}, 16'h0);
                chk("R9 res_ctrl mac", res_ctrl, exp_ctrl(s));
                chk("R10 res_adv mac", res_adv, exp_adv(d));
                chk("R10 res_link mac", {15'h0, res_link}, 16'(l));
            end
        end

        // R4: interrupted run does not accept, gaps do not break a run
        do_restart();
        push(mk(1, 1, 2)); push(mk(1, 1, 2)); push(mk(1, 0, 1)); push(mk(1, 1, 2));
        chk("R4 broken run no accept", {15'h0, tx_valid}, 16'h0);
        repeat (5) @(negedge clk);
        push(mk(1, 1, 2));
        chk("R4 still waiting", {15'h0, tx_valid}, 16'h0);
        push(mk(1, 1, 2));
        chk("R4 third copy accepted", {15'h0, tx_valid}, 16'h1);
        chk("R4 latched speed", {14'h0, rx_stat_speed}, 16'h2);
        repeat (3) @(negedge clk);

        // R8: sticky flag cleared by write-zero strobe
        chk("R8 done before clear", {15'h0, an_done}, 16'h1);
        repeat (4) @(negedge clk);
        chk("R8 done holds", {15'h0, an_done}, 16'h1);
        irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
        chk("R8 cleared", {15'h0, an_done}, 16'h0);
        chk("R8 result remains", res_ctrl, 16'h0040);

        // R5 and R12 in DONE: reserved ignored, valid word relatches
        push3(mk(1, 1, 3));
        chk("R5 reserved keeps speed", res_ctrl, 16'h0040);
        chk("R5 reserved keeps duplex", res_adv, 16'h0020);
        push3(mk(1, 0, 1));
        chk("R12 relatch speed", res_ctrl, 16'h2000);
        chk("R12 relatch duplex", res_adv, 16'h0040);
        chk("R12 stays done state", tx_word, 16'h4001);

        // R11: restart clears everything
        do_restart();
        chk("R11 done cleared", {15'h0, an_done}, 16'h0);
        chk("R11 res cleared", res_ctrl | res_adv | {15'h0, res_link}, 16'h0);

        // PHY role sweep
        role_phy = 1'b1;
        for (int c = 0; c < 16; c++) begin
            int l = (c >> 3) & 1;
            int d = (c >> 2) & 1;
            int s = c & 3;
            loc_link = l[0]; loc_full_duplex = d[0]; loc_speed = s[1:0];
            do_restart();
            @(negedge clk);
            chk("R2 advert valid", {15'h0, tx_valid}, 16'h1);
            chk("R2 advert word", tx_word, mk(l, d, s));
            chk("R7 no early done", {15'h0, an_done}, 16'h0);
            push3(16'h4001);
            chk("R7 done after acks", {15'h0, an_done}, 16'h1);
            chk("R9 res_ctrl phy", res_ctrl, (s == 3) ? 16'h0 : exp_ctrl(s));
            chk("R10 res_adv phy", res_adv, exp_adv(d));
            chk("R10 res_link phy", {15'h0, res_link}, 16'(l));
        end

        // R7: words without acknowledge bit or without bit 0 never complete
        do_restart();
        push3(16'h0001);
        chk("R7 no ack bit", {15'h0, an_done}, 16'h0);
        push3(16'h4000);
        chk("R4 no sync bit", {15'h0, an_done}, 16'h0);
        push(16'h4001); push(16'h4001);
        chk("R7 two copies only", {15'h0, an_done}, 16'h0);
        push(16'h4001);
        chk("R7 third copy", {15'h0, an_done}, 16'h1);

        // R1: PHY role IDLE then ADVERT
        @(negedge clk); restart = 1'b1;
        @(negedge clk); restart = 1'b0;
        chk("R1 idle silent", {15'h0, tx_valid}, 16'h0);
        @(negedge clk);
        chk("R1 advert entered", {15'h0, tx_valid}, 16'h1);

        finish_run();
    end
endmodule